// File: doc/BRIEF.md
# Queue Status Interrupt Controller

This block turns per-queue status flags from a 64-queue buffer manager into two interrupt lines. Queues 0 to 31 form the lower half and queues 32 to 63 the upper half. Each lower queue has a 3-bit source field that chooses one of four status flags (empty, nearly empty, nearly full, full) and may invert it. Each upper queue raises a request whenever it is not nearly empty; that condition is fixed.

Each half keeps a 32-bit enable register and a 32-bit pending register. A pending bit latches when its queue's condition holds while the queue is enabled. Software clears it by writing a one to it. A half's interrupt line is high while any bit is both pending and enabled. The block also reports the highest-numbered queue that is pending and enabled in each half, both on ports and through a read-only register, so that a handler can service queues from the top down without scanning the vector itself.

Register access uses a single-cycle write strobe with a 4-bit word address and a combinational read port. The status flags arrive as plain input vectors. Queue storage is handled elsewhere.

Top module: `qsic_top`

## Requirements
- R1: After reset every source field, enable bit and pending bit is zero. Both interrupt lines are low, both index ports read 0 with valid low, and every register address reads 0.
- R2: Source fields live at word addresses 0 to 3. Queue q uses word q/8, bits 4*(q%8)+2 down to 4*(q%8). Bit 4*(q%8)+3 is reserved: writes to it are dropped and it always reads 0.
- R3: For a lower queue, source bits [1:0] pick a flag: 0 empty, 1 nearly empty, 2 nearly full, 3 full. Source bit 2 set inverts the picked flag.
- R4: An upper queue's condition is the inverse of its nearly-empty flag. Writes to source words never change it.
- R5: At a clock edge where a queue's condition is true and its enable bit (word 4 lower, word 5 upper, bit = queue mod 32) is set, its pending bit (word 6 lower, word 7 upper) becomes 1. It stays 1 after the condition goes away, until it is cleared.
- R6: A write to a pending word clears exactly the bits written as 1. Bits written as 0 keep their value, and an all-ones write clears every bit whose condition is not being set at that edge.
- R7: When a clear of a bit and a new set of the same bit fall on the same edge, the bit ends up 1.
- R8: A queue whose enable bit is 0 never becomes pending.
- R9: Each interrupt line is high in exactly the cycles where its half has at least one bit that is both pending and enabled.
- R10: Each half's index port gives the highest queue number (0 to 31 within the half) that is both pending and enabled, with valid high. When no such queue exists, valid is low and the index is 0. Words 8 (lower) and 9 (upper) read bit 31 as valid and bits 4:0 as the index, with every other bit 0.
- R11: Writes to words 8 to 15 change no state. Words 10 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| lo_empty | input | 32 | Empty flag, queues 0-31 |
| lo_near_empty | input | 32 | Nearly-empty flag, queues 0-31 |
| lo_near_full | input | 32 | Nearly-full flag, queues 0-31 |
| lo_full | input | 32 | Full flag, queues 0-31 |
| hi_near_empty | input | 32 | Nearly-empty flag, queues 32-63 |
| irq_lo | output | 1 | Interrupt line, lower half |
| irq_hi | output | 1 | Interrupt line, upper half |
| lo_top_idx | output | 5 | Highest pending and enabled lower queue |
| lo_top_vld | output | 1 | lo_top_idx is meaningful |
| hi_top_idx | output | 5 | Highest pending and enabled upper queue, minus 32 |
| hi_top_vld | output | 1 | hi_top_idx is meaningful |

## Verification
The assertions assume that the flag vectors and the register strobe are stable around the active edge and hold known values once reset is released. They make no assumption that flags agree with each other: a queue may appear both empty and full at once. The stimulus therefore drives every input only at the falling edge and never leaves an input unknown after reset. It deliberately produces inconsistent flag combinations, and it lines up pending clears with new set conditions on the same edge, so that the set-over-clear priority is exercised rather than assumed.

// File: rtl/qsic_pkg.sv
package qsic_pkg;

  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 4;
  localparam int SLOT_W   = 4;
  localparam int SRC_W    = 3;

  // word addresses of the register map
  localparam logic [ADDR_W-1:0] A_EN_LO   = 4'd4;
  localparam logic [ADDR_W-1:0] A_EN_HI   = 4'd5;
  localparam logic [ADDR_W-1:0] A_PEND_LO = 4'd6;
  localparam logic [ADDR_W-1:0] A_PEND_HI = 4'd7;
  localparam logic [ADDR_W-1:0] A_TOP_LO  = 4'd8;
  localparam logic [ADDR_W-1:0] A_TOP_HI  = 4'd9;

  // flag order inside the 4-bit flag bundle, indexed by source bits [1:0]
  typedef enum logic [1:0] {
    FLG_EMPTY      = 2'd0,
    FLG_NEAR_EMPTY = 2'd1,
    FLG_NEAR_FULL  = 2'd2,
    FLG_FULL       = 2'd3
  } flag_sel_e;

  // condition selected by a source field: pick a flag, then optionally invert
  function automatic logic src_cond(input logic [SRC_W-1:0] src,
                                    input logic [3:0] flags);
    return flags[src[1:0]] ^ src[2];
  endfunction

endpackage

// File: rtl/qsic_src_sel.sv
module qsic_src_sel #(
  parameter int NQ     = 32,
  parameter int DATA_W = qsic_pkg::DATA_W,
  parameter int SLOT_W = qsic_pkg::SLOT_W,
  parameter int SRC_W  = qsic_pkg::SRC_W,
  localparam int SPR   = DATA_W / SLOT_W,
  localparam int NWORD = NQ / SPR,
  localparam int SEL_W = (NWORD > 1) ? $clog2(NWORD) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [SEL_W-1:0]             wr_sel,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [NQ-1:0]                f_empty,
  input  logic [NQ-1:0]                f_near_empty,
  input  logic [NQ-1:0]                f_near_full,
  input  logic [NQ-1:0]                f_full,
  output logic [NQ-1:0]                cond,
  output logic [NWORD-1:0][DATA_W-1:0] rd_words
);

  logic [NQ-1:0][SRC_W-1:0] src_r;
  logic [NQ-1:0]            slot_hit;

  // per-queue write decode brought out for the checker
  for (genvar q = 0; q < NQ; q++) begin : g_hit
    assign slot_hit[q] = wr_en && (wr_sel == SEL_W'(q / SPR));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_r <= '0;
    end else begin
      for (int q = 0; q < NQ; q++) begin
        if (slot_hit[q]) src_r[q] <= wdata[(q % SPR) * SLOT_W +: SRC_W];
      end
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_cond
    assign cond[q] = qsic_pkg::src_cond(src_r[q],
                       {f_full[q], f_near_full[q], f_near_empty[q], f_empty[q]});
  end

  always_comb begin
    rd_words = '0;
    for (int q = 0; q < NQ; q++) begin
      rd_words[q / SPR][(q % SPR) * SLOT_W +: SRC_W] = src_r[q];
    end
  end

  // reserved slot bits are never stored
  logic [NQ*(SLOT_W-SRC_W)-1:0] unused_rsvd;
  for (genvar q = 0; q < NQ; q++) begin : g_rsvd
    assign unused_rsvd[q*(SLOT_W-SRC_W) +: (SLOT_W-SRC_W)] =
      wdata[(q % SPR) * SLOT_W + SRC_W +: (SLOT_W-SRC_W)];
  end

  // R11: without a write strobe no source field moves
  assert_src_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(src_r));

  // R2: a written field takes the written slot value on the next edge
  assert_src_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == '0) |=> (src_r[0] == $past(wdata[SRC_W-1:0])));

endmodule

// File: rtl/qsic_half.sv
module qsic_half #(
  parameter int W     = 32,
  localparam int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     cond,
  input  logic             en_we,
  input  logic             clr_we,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     en_q,
  output logic [W-1:0]     pend_q,
  output logic             irq,
  output logic             top_vld,
  output logic [IDX_W-1:0] top_idx
);

  logic [W-1:0] set_vec;
  logic [W-1:0] clr_vec;
  logic [W-1:0] active;

  // highest set bit of a vector, with a found flag in the top position
  function automatic logic [IDX_W:0] highest(input logic [W-1:0] v);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = 0; i < W; i++) begin
      if (v[i]) r = {1'b1, IDX_W'(i)};
    end
    return r;
  endfunction

  assign set_vec = cond & en_q;
  assign clr_vec = clr_we ? wdata : '0;
  assign active  = pend_q & en_q;
  assign irq     = |active;
  assign {top_vld, top_idx} = highest(active);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_we) en_q <= wdata;
      pend_q <= (pend_q & ~clr_vec) | set_vec;
    end
  end

  // R8: a bit only rises where a set was presented on the previous edge
  assert_rise_needs_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(set_vec)) == '0));

  // R7: every set request lands, even with a clear on the same edge
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

  // R6: cleared bits with no competing set drop
  assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((pend_q & $past(clr_vec & ~set_vec)) == '0));

  // R5: without a clear, pending bits never fall
  assert_pend_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((~pend_q & $past(pend_q)) == '0));

  // R9: the line and the index valid flag agree
  assert_irq_vld_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == top_vld);

  // R10: reported index is active and nothing above it is
  assert_top_highest_R10: assert property (@(posedge clk) disable iff (!rst_n)
    top_vld |-> ((active >> top_idx) == W'(1)));

endmodule

// File: rtl/qsic_top.sv
module qsic_top #(
  parameter int DATA_W = qsic_pkg::DATA_W,
  parameter int ADDR_W = qsic_pkg::ADDR_W,
  localparam int HALF_Q = DATA_W,
  localparam int IDX_W  = $clog2(HALF_Q),
  localparam int SPR    = DATA_W / qsic_pkg::SLOT_W,
  localparam int NWORD  = HALF_Q / SPR,
  localparam int SEL_W  = (NWORD > 1) ? $clog2(NWORD) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [HALF_Q-1:0] lo_empty,
  input  logic [HALF_Q-1:0] lo_near_empty,
  input  logic [HALF_Q-1:0] lo_near_full,
  input  logic [HALF_Q-1:0] lo_full,
  input  logic [HALF_Q-1:0] hi_near_empty,
  output logic              irq_lo,
  output logic              irq_hi,
  output logic [IDX_W-1:0]  lo_top_idx,
  output logic              lo_top_vld,
  output logic [IDX_W-1:0]  hi_top_idx,
  output logic              hi_top_vld
);
  import qsic_pkg::*;

  logic                        src_hit;
  logic [HALF_Q-1:0]           lo_cond;
  logic [HALF_Q-1:0]           hi_cond;
  logic [NWORD-1:0][DATA_W-1:0] src_words;
  logic [HALF_Q-1:0]           en_lo, en_hi, pend_lo, pend_hi;

  assign src_hit = reg_wr && (reg_addr < ADDR_W'(NWORD));
  assign hi_cond = ~hi_near_empty;

  qsic_src_sel #(.NQ(HALF_Q), .DATA_W(DATA_W)) u_src (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (src_hit),
    .wr_sel       (reg_addr[SEL_W-1:0]),
    .wdata        (reg_wdata),
    .f_empty      (lo_empty),
    .f_near_empty (lo_near_empty),
    .f_near_full  (lo_near_full),
    .f_full       (lo_full),
    .cond         (lo_cond),
    .rd_words     (src_words)
  );

  qsic_half #(.W(HALF_Q)) u_lo (
    .clk     (clk),
    .rst_n   (rst_n),
    .cond    (lo_cond),
    .en_we   (reg_wr && reg_addr == A_EN_LO),
    .clr_we  (reg_wr && reg_addr == A_PEND_LO),
    .wdata   (reg_wdata),
    .en_q    (en_lo),
    .pend_q  (pend_lo),
    .irq     (irq_lo),
    .top_vld (lo_top_vld),
    .top_idx (lo_top_idx)
  );

  qsic_half #(.W(HALF_Q)) u_hi (
    .clk     (clk),
    .rst_n   (rst_n),
    .cond    (hi_cond),
    .en_we   (reg_wr && reg_addr == A_EN_HI),
    .clr_we  (reg_wr && reg_addr == A_PEND_HI),
    .wdata   (reg_wdata),
    .en_q    (en_hi),
    .pend_q  (pend_hi),
    .irq     (irq_hi),
    .top_vld (hi_top_vld),
    .top_idx (hi_top_idx)
  );

  function automatic logic [DATA_W-1:0] top_word(input logic v, input logic [IDX_W-1:0] i);
    return {v, {(DATA_W-1-IDX_W){1'b0}}, i};
  endfunction

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < ADDR_W'(NWORD)) begin
      reg_rdata = src_words[reg_addr[SEL_W-1:0]];
    end else begin
      case (reg_addr)
        A_EN_LO:   reg_rdata = en_lo;
        A_EN_HI:   reg_rdata = en_hi;
        A_PEND_LO: reg_rdata = pend_lo;
        A_PEND_HI: reg_rdata = pend_hi;
        A_TOP_LO:  reg_rdata = top_word(lo_top_vld, lo_top_idx);
        A_TOP_HI:  reg_rdata = top_word(hi_top_vld, hi_top_idx);
        default:   reg_rdata = '0;
      endcase
    end
  end

  // R4: upper pending bits never rise while the queue is nearly empty
  assert_hi_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_hi & ~$past(pend_hi) & $past(hi_near_empty)) == '0));

  // R10: index port is zero whenever nothing is reported
  assert_idx_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_top_vld |-> (lo_top_idx == '0));

endmodule

// File: tb/qsic_top_test.sv
module qsic_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] fe = '0, fne = '0, fnf = '0, ff = '0, hne = '1;
  logic        irq_lo, irq_hi, lo_top_vld, hi_top_vld;
  logic [4:0]  lo_top_idx, hi_top_idx;

  always #4 clk = ~clk;   // 125 MHz

  qsic_top uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lo_empty(fe), .lo_near_empty(fne), .lo_near_full(fnf), .lo_full(ff),
    .hi_near_empty(hne),
    .irq_lo(irq_lo), .irq_hi(irq_hi),
    .lo_top_idx(lo_top_idx), .lo_top_vld(lo_top_vld),
    .hi_top_idx(hi_top_idx), .hi_top_vld(hi_top_vld)
  );

  // reference state: plain per-queue integers
  int m_src [32];
  int m_en  [64];
  int m_pend[64];
  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";

  function automatic int cond_of(int q);
    int f;
    if (q >= 32) return (hne[q-32] == 1'b0) ? 1 : 0;
    case (m_src[q] % 4)
      0: f = fe[q];
      1: f = fne[q];
      2: f = fnf[q];
      default: f = ff[q];
    endcase
    if (m_src[q] >= 4) f = 1 - f;
    return f;
  endfunction

  function automatic int top_of(int base);
    for (int q = 31; q >= 0; q--)
      if (m_pend[base+q] == 1 && m_en[base+q] == 1) return q;
    return -1;
  endfunction

  function automatic logic [31:0] vec_of(int base, int which);
    logic [31:0] v = '0;
    for (int q = 0; q < 32; q++)
      v[q] = (which == 0) ? (m_en[base+q] == 1) : (m_pend[base+q] == 1);
    return v;
  endfunction

  function automatic logic [31:0] exp_read(int a);
    logic [31:0] v = '0;
    int t;
    if (a < 4) begin
      for (int k = 0; k < 8; k++) v[4*k +: 3] = 3'(m_src[8*a+k]);
      return v;
    end
    case (a)
      4: return vec_of(0, 0);
      5: return vec_of(32, 0);
      6: return vec_of(0, 1);
      7: return vec_of(32, 1);
      8, 9: begin
        t = top_of((a == 8) ? 0 : 32);
        if (t >= 0) v = 32'h8000_0000 | 32'(t);
        return v;
      end
      default: return '0;
    endcase
  endfunction

  task automatic check(string what, logic [31:0] got, logic [31:0] exp);
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s got %h exp %h", cur_req, what, got, exp);
    end
  endtask

  task automatic compare_all();
    int tl, th;
    vectors++;
    tl = top_of(0);
    th = top_of(32);
    check("reg_rdata", reg_rdata, exp_read(int'(reg_addr)));
    check("irq_lo R9", 32'(irq_lo), 32'(tl >= 0));
    check("irq_hi R9", 32'(irq_hi), 32'(th >= 0));
    check("lo_top R10", {lo_top_vld, lo_top_idx}, (tl >= 0) ? 32'(32 + tl) : 32'd0);
    check("hi_top R10", {hi_top_vld, hi_top_idx}, (th >= 0) ? 32'(32 + th) : 32'd0);
  endtask

  task automatic model_edge();
    int set [64];
    for (int q = 0; q < 64; q++) set[q] = (cond_of(q) == 1 && m_en[q] == 1) ? 1 : 0;
    if (reg_wr) begin
      if (reg_addr < 4)
        for (int k = 0; k < 8; k++) m_src[8*reg_addr+k] = int'(reg_wdata[4*k +: 3]);
      if (reg_addr == 4) for (int q = 0; q < 32; q++) m_en[q] = reg_wdata[q];
      if (reg_addr == 5) for (int q = 0; q < 32; q++) m_en[32+q] = reg_wdata[q];
      if (reg_addr == 6) for (int q = 0; q < 32; q++) if (reg_wdata[q]) m_pend[q] = 0;
      if (reg_addr == 7) for (int q = 0; q < 32; q++) if (reg_wdata[q]) m_pend[32+q] = 0;
    end
    for (int q = 0; q < 64; q++) if (set[q] == 1) m_pend[q] = 1;
  endtask

  // one cycle: drive at the falling edge, compare, then advance the model
  task automatic step(bit w, int a, logic [31:0] d);
    @(negedge clk);
    reg_wr = w; reg_addr = 4'(a); reg_wdata = d;
    #1;
    compare_all();
    @(posedge clk);
    if (rst_n) model_edge();
    #1;
  endtask

  task automatic rd(int a);
    step(1'b0, a, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog R9 got hung exp done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int q = 0; q < 64; q++) begin m_en[q] = 0; m_pend[q] = 0; end
    for (int q = 0; q < 32; q++) m_src[q] = 0;
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state on every address
    cur_req = "R1";
    for (int a = 0; a < 16; a++) rd(a);

    // R2: source layout, reserved bits dropped
    cur_req = "R2";
    step(1'b1, 0, 32'hFFFF_FFFF);
    step(1'b1, 1, 32'h8A5C_3E71);
    step(1'b1, 3, 32'h1234_5678);
    for (int a = 0; a < 4; a++) rd(a);

    // R3: every source code on lower queues, inconsistent flag mixes
    cur_req = "R3";
    step(1'b1, 0, 32'h7654_3210);
    step(1'b1, 1, 32'h0123_4567);
    step(1'b1, 4, 32'h0000_FFFF);
    for (int i = 0; i < 24; i++) begin
      fe = $urandom; fne = $urandom; fnf = $urandom; ff = $urandom;
      step(1'b1, 6, 32'hFFFF_FFFF);
      rd(6);
      rd(8);
    end

    // R4: upper condition is not nearly empty, source writes irrelevant
    cur_req = "R4";
    step(1'b1, 5, 32'hFFFF_FFFF);
    hne = 32'hFFFF_FFFE;
    step(1'b1, 2, 32'h7777_7777);
    rd(7);
    hne = 32'h0F0F_FFFF;
    rd(7); rd(9);

    // R5: pending survives after the condition goes away
    cur_req = "R5";
    hne = '1;
    step(1'b1, 7, 32'hFFFF_FFFF);
    hne = 32'hFFFF_DFFF;
    rd(7);
    hne = '1;
    rd(7); rd(9); rd(7);

    // R6: partial clear keeps unwritten bits
    cur_req = "R6";
    hne = 32'h0000_FFFF;
    rd(7);
    hne = '1;
    step(1'b1, 7, 32'h00F0_0000);
    rd(7);
    step(1'b1, 7, 32'hFFFF_FFFF);
    rd(7); rd(9);

    // R7: clear and set on the same edge
    cur_req = "R7";
    hne = 32'h7FFF_FFFE;
    step(1'b1, 7, 32'hFFFF_FFFF);
    rd(7);
    hne = '1;
    step(1'b1, 7, 32'hFFFF_FFFF);
    rd(7);

    // R8: disabled queues never latch
    cur_req = "R8";
    step(1'b1, 5, 32'h0000_0000);
    step(1'b1, 4, 32'h0000_0000);
    hne = '0; fe = '1; fne = '1; fnf = '1; ff = '1;
    rd(6); rd(7); rd(8); rd(9);
    step(1'b1, 4, 32'h0000_0001);
    rd(6); rd(8);

    // R11: read-only and unused words keep state
    cur_req = "R11";
    for (int a = 8; a < 16; a++) step(1'b1, a, 32'hFFFF_FFFF);
    for (int a = 0; a < 16; a++) rd(a);

    // R9: mixed random traffic
    cur_req = "R9";
    for (int i = 0; i < 4000; i++) begin
      fe = $urandom; fne = $urandom; fnf = $urandom; ff = $urandom;
      hne = $urandom | $urandom;
      if ($urandom % 3 == 0) step(1'b1, int'($urandom % 16), $urandom);
      else rd(int'($urandom % 16));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule